// File: doc/BRIEF.md
# Vector Load/Store Address Generator

This block turns one vector memory command into a sequence of lane-grouped byte addresses. A command carries a base address, a mode, an element width, an element count (the vector length) and, depending on the mode, a signed stride or a stream of per-element byte offsets. The generator emits `LANES` addresses at a time, one group on every second cycle. Each group comes with a lane-enable mask and per-lane byte strobes for a 32-bit memory word.

A command is accepted while the block is idle. Its fields are captured during a setup cycle. The groups then follow, with a gap cycle after each one, and a single drain cycle ends the command. Lanes past the vector length in the final group are switched off. An element whose address is not aligned to its width is not accessed: its lane is disabled and flagged. The data crossbar and the memory are outside the block.

Top module: `vag_top`

## Requirements
- R1: With `mode_i`=0 (unit stride), element e has address base + e*B. B is the element size in bytes, selected by `ew_i` (0 gives 1 byte, 1 gives 2 bytes, 2 gives 4 bytes).
- R2: With `mode_i`=1 (strided), element e has address base + e*S*B modulo 2^AW. S is `stride_i`, read as a two's-complement count of elements.
- R3: With `mode_i`=2 (indexed), element e has address base + offset_e. offset_e is a byte offset taken from `idx_i` lane l of group g (e = g*LANES + l). It must be presented in a cycle where `idx_pull_o` is high, and it is sampled at the following rising edge.
- R4: Group g, lane l carries element g*LANES + l. Lanes whose element index is not below the vector length have `lane_en_o`, `misal_o` and `be_o` all zero.
- R5: Take the edge that accepts `start_i` as edge 0, and let G = ceil(VL/LANES). Group g is valid (`grp_valid_o`) in the cycle after edge 2g+1. `done_o` is high for the single cycle after edge 2G+1. `busy_o` is high from edge 0 up to edge 2G+2, so the command occupies 2G+2 cycles.
- R6: A vector length of 0 produces no groups. `done_o` is high in the cycle after edge 1.
- R7: `be_o` bit 4l+k enables byte k of lane l's 32-bit word. 1-byte elements set bit addr[1:0]. 2-byte elements set bits addr[1:0] and addr[1:0]+1. 4-byte elements set all four bits.
- R8: An element is misaligned when it is 2 bytes wide with addr[0]=1, or 4 bytes wide with addr[1:0]≠0. For a misaligned element, its lane has `lane_en_o`=0, `be_o`=0 and `misal_o`=1, and `fault_o` is high for that group.
- R9: `start_i` is ignored while `busy_o` is high. The running command's addresses and timing do not change.
- R10: After reset, `busy_o`, `grp_valid_o`, `done_o`, `idx_pull_o`, `fault_o` and `lane_en_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to start a command; taken only when idle |
| mode_i | input | 2 | 0 unit stride, 1 strided, 2 indexed |
| ew_i | input | 2 | Element width: 0 byte, 1 halfword, 2 word |
| base_i | input | AW | Byte base address |
| stride_i | input | AW | Signed stride in elements (strided mode) |
| vlen_i | input | VLW | Vector length in elements |
| idx_i | input | LANES*AW | Byte offsets for the next group (indexed mode) |
| idx_pull_o | output | 1 | `idx_i` is sampled at the coming edge |
| grp_valid_o | output | 1 | Address group valid this cycle |
| addr_o | output | LANES*AW | Per-lane byte addresses |
| lane_en_o | output | LANES | Lane performs an access |
| be_o | output | LANES*4 | Per-lane byte strobes |
| misal_o | output | LANES | Lane element misaligned, access suppressed |
| fault_o | output | 1 | Some lane of this group is misaligned |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | Drain cycle of the command |

## Verification
The hardest situation to reach is a group in which live aligned lanes, misaligned lanes and lanes past the vector length all appear together. The bench creates it with an indexed halfword command whose offset pattern makes some elements odd, and whose length does not fill the last group. It also pulses `start_i` in the middle of a command with a different base, and checks that every later address still follows the original command. A zero-length command and a single-element command exercise the shortest timing paths.

// File: rtl/vag_pkg.sv
package vag_pkg;

  typedef enum logic [1:0] {
    AM_UNIT   = 2'd0,
    AM_STRIDE = 2'd1,
    AM_INDEX  = 2'd2,
    AM_RSVD   = 2'd3
  } amode_e;

  typedef enum logic [1:0] {
    EW_BYTE = 2'd0,
    EW_HALF = 2'd1,
    EW_WORD = 2'd2,
    EW_RSVD = 2'd3
  } ewidth_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_ADDR  = 3'd2,
    ST_GAP   = 3'd3,
    ST_DRAIN = 3'd4
  } vstate_e;

  // log2 of the element size in bytes; the reserved code acts as a word
  function automatic int unsigned ew_shift(input ewidth_e w);
    case (w)
      EW_BYTE: return 0;
      EW_HALF: return 1;
      default: return 2;
    endcase
  endfunction

  function automatic logic [2:0] ew_bytes(input ewidth_e w);
    return 3'(1 << ew_shift(w));
  endfunction

  // natural alignment of an element from the two low address bits
  function automatic logic ew_aligned(input logic [1:0] lo, input ewidth_e w);
    case (w)
      EW_BYTE: return 1'b1;
      EW_HALF: return ~lo[0];
      default: return (lo == 2'b00);
    endcase
  endfunction

  // byte strobes inside one 32-bit word
  function automatic logic [3:0] ew_strobe(input logic [1:0] lo, input ewidth_e w);
    case (w)
      EW_BYTE: return 4'b0001 << lo;
      EW_HALF: return 4'b0011 << lo;
      default: return 4'b1111;
    endcase
  endfunction

endpackage

// File: rtl/vag_seq.sv
module vag_seq
  import vag_pkg::*;
#(
  parameter int LANES = 4,
  parameter int VLW   = 7
)(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [VLW-1:0] vlen_i,
  output vstate_e        state_o,
  output logic           accept_o,
  output logic           load_o,
  output logic [VLW-1:0] rem_o
);

  vstate_e        state_q, state_d;
  logic [VLW-1:0] rem_q;
  logic           more;

  assign more     = (rem_q != '0);
  assign accept_o = start_i && (state_q == ST_IDLE);
  assign load_o   = ((state_q == ST_SETUP) || (state_q == ST_GAP)) && more;
  assign state_o  = state_q;
  assign rem_o    = rem_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (accept_o) state_d = ST_SETUP;
      ST_SETUP: state_d = more ? ST_ADDR : ST_DRAIN;
      ST_ADDR:  state_d = ST_GAP;
      ST_GAP:   state_d = more ? ST_ADDR : ST_DRAIN;
      ST_DRAIN: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept_o) begin
        rem_q <= vlen_i;
      end else if (load_o) begin
        rem_q <= (int'(rem_q) > LANES) ? rem_q - VLW'(LANES) : '0;
      end
    end
  end

endmodule

// File: rtl/vag_lane.sv
module vag_lane
  import vag_pkg::*;
#(
  parameter int AW      = 32,
  parameter int LANE_ID = 0
)(
  input  amode_e        mode_i,
  input  ewidth_e       ew_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] grp_base_i,
  input  logic [AW-1:0] step_i,
  input  logic [AW-1:0] off_i,
  input  logic          live_i,
  output logic [AW-1:0] addr_o,
  output logic          en_o,
  output logic          misal_o,
  output logic [3:0]    be_o
);

  logic ok;

  always_comb begin
    if (mode_i == AM_INDEX) addr_o = base_i + off_i;
    else                    addr_o = grp_base_i + step_i * AW'(LANE_ID);
    ok      = ew_aligned(addr_o[1:0], ew_i);
    en_o    = live_i && ok;
    misal_o = live_i && !ok;
    be_o    = en_o ? ew_strobe(addr_o[1:0], ew_i) : 4'b0000;
  end

endmodule

// File: rtl/vag_top.sv
module vag_top
  import vag_pkg::*;
#(
  parameter int LANES = 4,
  parameter int AW    = 32,
  parameter int MAXVL = 64,
  parameter int VLW   = $clog2(MAXVL + 1)
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [1:0]          mode_i,
  input  logic [1:0]          ew_i,
  input  logic [AW-1:0]       base_i,
  input  logic [AW-1:0]       stride_i,
  input  logic [VLW-1:0]      vlen_i,
  input  logic [LANES*AW-1:0] idx_i,
  output logic                idx_pull_o,
  output logic                grp_valid_o,
  output logic [LANES*AW-1:0] addr_o,
  output logic [LANES-1:0]    lane_en_o,
  output logic [LANES*4-1:0]  be_o,
  output logic [LANES-1:0]    misal_o,
  output logic                fault_o,
  output logic                busy_o,
  output logic                done_o
);

  vstate_e        state;
  logic           accept, load;
  logic [VLW-1:0] rem;

  amode_e         mode_q;
  ewidth_e        ew_q;
  logic [AW-1:0]  base_q, step_q, grp_base_q, step_in;

  logic [AW-1:0]  lane_addr [LANES];
  logic [3:0]     lane_be   [LANES];
  logic [LANES-1:0] lane_en, lane_mis;

  logic [AW-1:0]  addr_q [LANES];
  logic [3:0]     be_q   [LANES];
  logic [LANES-1:0] en_q, mis_q;

  vag_seq #(.LANES(LANES), .VLW(VLW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .vlen_i   (vlen_i),
    .state_o  (state),
    .accept_o (accept),
    .load_o   (load),
    .rem_o    (rem)
  );

  // distance in bytes between neighbouring elements
  always_comb begin
    if (amode_e'(mode_i) == AM_STRIDE) step_in = stride_i << ew_shift(ewidth_e'(ew_i));
    else                               step_in = AW'(1) << ew_shift(ewidth_e'(ew_i));
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    vag_lane #(.AW(AW), .LANE_ID(l)) u_lane (
      .mode_i     (mode_q),
      .ew_i       (ew_q),
      .base_i     (base_q),
      .grp_base_i (grp_base_q),
      .step_i     (step_q),
      .off_i      (idx_i[l*AW +: AW]),
      .live_i     (int'(rem) > l),
      .addr_o     (lane_addr[l]),
      .en_o       (lane_en[l]),
      .misal_o    (lane_mis[l]),
      .be_o       (lane_be[l])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= AM_UNIT;
      ew_q       <= EW_BYTE;
      base_q     <= '0;
      step_q     <= '0;
      grp_base_q <= '0;
      en_q       <= '0;
      mis_q      <= '0;
      for (int l = 0; l < LANES; l++) begin
        addr_q[l] <= '0;
        be_q[l]   <= '0;
      end
    end else begin
      if (accept) begin
        mode_q     <= amode_e'(mode_i);
        ew_q       <= ewidth_e'(ew_i);
        base_q     <= base_i;
        step_q     <= step_in;
        grp_base_q <= base_i;
      end
      if (load) begin
        grp_base_q <= grp_base_q + step_q * AW'(LANES);
        en_q       <= lane_en;
        mis_q      <= lane_mis;
        for (int l = 0; l < LANES; l++) begin
          addr_q[l] <= lane_addr[l];
          be_q[l]   <= lane_be[l];
        end
      end
    end
  end

  assign grp_valid_o = (state == ST_ADDR);
  assign idx_pull_o  = load && (mode_q == AM_INDEX);
  assign busy_o      = (state != ST_IDLE);
  assign done_o      = (state == ST_DRAIN);
  assign lane_en_o   = en_q & {LANES{grp_valid_o}};
  assign misal_o     = mis_q & {LANES{grp_valid_o}};
  assign fault_o     = grp_valid_o && (mis_q != '0);

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      addr_o[l*AW +: AW] = addr_q[l];
      be_o[l*4 +: 4]     = grp_valid_o ? be_q[l] : 4'b0000;
    end
  end

endmodule

// File: rtl/vag_chk.sv
module vag_chk
  import vag_pkg::*;
#(
  parameter int LANES = 4,
  parameter int AW    = 32
)(
  input logic                clk,
  input logic                rst_n,
  input logic                grp_valid,
  input logic                done,
  input logic                busy,
  input logic                idx_pull,
  input logic [LANES-1:0]    lane_en,
  input logic [LANES-1:0]    misal,
  input logic [LANES*4-1:0]  be,
  input logic [LANES*AW-1:0] addr,
  input amode_e              mode_q,
  input ewidth_e             ew_q,
  input logic [AW-1:0]       base_q
);

  a_r5_gap_after_group: assert property (@(posedge clk) disable iff (!rst_n)
    grp_valid |=> !grp_valid);

  a_r5_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  a_r3_pull_then_group: assert property (@(posedge clk) disable iff (!rst_n)
    idx_pull |=> grp_valid);

  a_r4_lane0_carries: assert property (@(posedge clk) disable iff (!rst_n)
    grp_valid |-> (lane_en[0] || misal[0]));

  a_r9_base_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(base_q));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!grp_valid && !done && lane_en == '0));

  for (genvar l = 0; l < LANES; l++) begin : g_be
    a_r7_be_off_lane: assert property (@(posedge clk) disable iff (!rst_n)
      !lane_en[l] |-> (be[l*4 +: 4] == 4'b0000));
  end

  if (LANES >= 2) begin : g_adj
    a_r1_unit_adjacent: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_valid && mode_q == AM_UNIT && lane_en[1:0] == 2'b11) |->
      (addr[2*AW-1:AW] == addr[AW-1:0] + AW'(ew_bytes(ew_q))));
  end

endmodule

bind vag_top vag_chk #(.LANES(LANES), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .grp_valid (grp_valid_o),
  .done      (done_o),
  .busy      (busy_o),
  .idx_pull  (idx_pull_o),
  .lane_en   (lane_en_o),
  .misal     (misal_o),
  .be        (be_o),
  .addr      (addr_o),
  .mode_q    (mode_q),
  .ew_q      (ew_q),
  .base_q    (base_q)
);

// File: tb/sim_vag_top.sv
module sim_vag_top;

  localparam int L  = 4;
  localparam int AW = 32;
  localparam int VW = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [1:0]    mode_i = '0;
  logic [1:0]    ew_i = '0;
  logic [AW-1:0] base_i = '0;
  logic [AW-1:0] stride_i = '0;
  logic [VW-1:0] vlen_i = '0;
  logic [L*AW-1:0] idx_i = '0;
  logic          idx_pull_o, grp_valid_o, fault_o, busy_o, done_o;
  logic [L*AW-1:0] addr_o;
  logic [L-1:0]  lane_en_o, misal_o;
  logic [L*4-1:0] be_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  vag_top #(.LANES(L), .AW(AW), .MAXVL(64)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i), .ew_i(ew_i),
    .base_i(base_i), .stride_i(stride_i), .vlen_i(vlen_i), .idx_i(idx_i),
    .idx_pull_o(idx_pull_o), .grp_valid_o(grp_valid_o), .addr_o(addr_o),
    .lane_en_o(lane_en_o), .be_o(be_o), .misal_o(misal_o), .fault_o(fault_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] idx_of(input int e, input int kind);
    if (kind == 0) return 32'(e * 12 + 4);
    return 32'(e * 6 + ((e % 3 == 2) ? 1 : 0));
  endfunction

  function automatic logic aligned_m(input logic [31:0] a, input logic [1:0] ew);
    if (ew == 2'd0) return 1'b1;
    if (ew == 2'd1) return !a[0];
    return a[1:0] == 2'b00;
  endfunction

  function automatic logic [3:0] strobe_m(input logic [31:0] a, input logic [1:0] ew);
    if (ew == 2'd0) return 4'(1 << a[1:0]);
    if (ew == 2'd1) return 4'(3 << a[1:0]);
    return 4'hF;
  endfunction

  // one command; expectations computed from the requirements
  task automatic run_op(input string tag, input logic [1:0] md, input logic [1:0] ew,
                        input logic [31:0] base, input logic [31:0] stride,
                        input int vl, input int kind, input bit poke);
    int g_cnt = (vl + L - 1) / L;
    int pulls = 0;
    string treq = (vl == 0) ? "R6" : "R5";
    @(negedge clk);
    mode_i = md; ew_i = ew; base_i = base; stride_i = stride; vlen_i = VW'(vl); start_i = 1'b1;
    @(posedge clk);
    for (int c = 0; c <= 2 * g_cnt + 2; c++) begin
      @(negedge clk);
      start_i = 1'b0;
      if (poke && c == 2) begin
        start_i = 1'b1; base_i = 32'hDEAD_0000; mode_i = 2'd1; stride_i = 32'd9;
      end
      if (idx_pull_o) begin
        for (int l = 0; l < L; l++) idx_i[l*AW +: AW] = idx_of(pulls * L + l, kind);
        pulls++;
      end
      begin
        bit vexp = (c % 2 == 1) && ((c - 1) / 2 < g_cnt);
        chk(treq, $sformatf("grp_valid c=%0d", c), 64'(grp_valid_o), 64'(vexp));
        chk(treq, $sformatf("done c=%0d", c), 64'(done_o), 64'(c == 2 * g_cnt + 1));
        chk(treq, $sformatf("busy c=%0d", c), 64'(busy_o), 64'(c <= 2 * g_cnt + 1));
        if (vexp && grp_valid_o) begin
          int g = (c - 1) / 2;
          logic fexp = 1'b0;
          for (int l = 0; l < L; l++) begin
            int e = g * L + l;
            logic [31:0] ea;
            logic live = (e < vl);
            logic ok;
            if (md == 2'd2)      ea = base + idx_of(e, kind);
            else if (md == 2'd1) ea = base + 32'(e) * stride * (32'd1 << ew);
            else                 ea = base + 32'(e) * (32'd1 << ew);
            ok = aligned_m(ea, ew);
            if (live && !ok) fexp = 1'b1;
            if (live) chk(tag, $sformatf("addr e=%0d", e), 64'(addr_o[l*AW +: AW]), 64'(ea));
            chk("R4", $sformatf("lane_en e=%0d", e), 64'(lane_en_o[l]), 64'(live && ok));
            chk("R8", $sformatf("misal e=%0d", e), 64'(misal_o[l]), 64'(live && !ok));
            chk("R7", $sformatf("be e=%0d", e), 64'(be_o[l*4 +: 4]),
                64'((live && ok) ? strobe_m(ea, ew) : 4'h0));
          end
          chk("R8", $sformatf("fault g=%0d", g), 64'(fault_o), 64'(fexp));
        end
      end
    end
    start_i = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R10", "busy", 64'(busy_o), 64'(0));
    chk("R10", "grp_valid", 64'(grp_valid_o), 64'(0));
    chk("R10", "done", 64'(done_o), 64'(0));
    chk("R10", "idx_pull", 64'(idx_pull_o), 64'(0));
    chk("R10", "fault", 64'(fault_o), 64'(0));
    chk("R10", "lane_en", 64'(lane_en_o), 64'(0));
  endtask

  task automatic t_unit();
    run_op("R1", 2'd0, 2'd0, 32'h0000_1000, 32'd0, 10, 0, 1'b0);
    run_op("R1", 2'd0, 2'd2, 32'h0000_2000, 32'd0, 8, 0, 1'b0);
  endtask

  task automatic t_stride();
    run_op("R2", 2'd1, 2'd1, 32'h0000_2002, 32'd3, 7, 0, 1'b0);
    run_op("R2", 2'd1, 2'd2, 32'h0000_3000, 32'hFFFF_FFFE, 5, 0, 1'b0);
  endtask

  task automatic t_index();
    run_op("R3", 2'd2, 2'd2, 32'h0000_4000, 32'd0, 9, 0, 1'b0);
  endtask

  task automatic t_misalign();
    run_op("R3", 2'd2, 2'd1, 32'h0000_5000, 32'd0, 11, 1, 1'b0);
    run_op("R2", 2'd1, 2'd2, 32'h0000_6001, 32'd1, 6, 0, 1'b0);
  endtask

  task automatic t_short();
    run_op("R6", 2'd0, 2'd2, 32'h0000_7000, 32'd0, 0, 0, 1'b0);
    run_op("R1", 2'd0, 2'd1, 32'h0000_7100, 32'd0, 1, 0, 1'b0);
  endtask

  task automatic t_busy_start();
    run_op("R9", 2'd0, 2'd0, 32'h0000_8003, 32'd0, 13, 0, 1'b1);
    repeat (2) @(negedge clk);
    chk("R9", "idle after poked command", 64'(busy_o), 64'(0));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_unit();
    t_stride();
    t_index();
    t_misalign();
    t_short();
    t_busy_start();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R5 watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule